// File: doc/BRIEF.md
# Bit Test, Modify and Scan Unit

This unit performs single-bit operations and bit searches on a 16-bit or 32-bit operand. A request names an operation, an operand size, the operand and a bit position. The four test operations report the chosen bit through the carry flag. Three of them then force that bit high, force it low or invert it, and return the changed operand with a write strobe. The two scan operations search the operand for the lowest or the highest set bit. They return its position with a separate write strobe and report through the zero flag whether any set bit was found.

The unit is meant to sit beside an integer datapath. Each result is registered once, one clock after the request strobe, and a one-cycle done pulse marks it. The write strobes tell the surrounding datapath whether the destination should take the result. Each flag is held in its own register. An operation changes only the flag it owns, and the other flag keeps its last value.

Top module: `bit_ops_unit`

## Requirements
- R1: During and right after reset, `res_data`, `res_index`, `flag_c`, `flag_z`, `res_data_we`, `res_index_we` and `res_done` are all 0.
- R2: Opcode 0 (plain test) loads the original value of the selected bit into `flag_c`. It returns the operand unchanged on `res_data` and keeps `res_data_we` at 0.
- R3: Opcode 1 sets the selected bit, opcode 2 clears it and opcode 3 inverts it. Each first copies the original bit into `flag_c` and asserts `res_data_we` for the result cycle.
- R4: The bit position is reduced modulo the operand width: `req_pos[4:0]` when `req_wide`=1 (32-bit), `req_pos[3:0]` when `req_wide`=0 (16-bit). In 16-bit mode, bits 31:16 of the operand pass through to `res_data` unchanged.
- R5: Opcode 4 (forward scan) returns on `res_index` the position of the least significant 1 bit of the operand and asserts `res_index_we`.
- R6: Opcode 5 (reverse scan) returns on `res_index` the position of the most significant 1 bit of the operand and asserts `res_index_we`.
- R7: A scan sets `flag_z` to 1 when the operand is zero and clears it otherwise. When the operand is zero, `res_index_we` stays 0 and `res_index` keeps its previous value. In 16-bit mode only bits 15:0 take part in the scan. Scans return the operand unchanged on `res_data` with `res_data_we` at 0.
- R8: Test operations (opcodes 0 to 3) leave `flag_z` unchanged. Scans (opcodes 4 and 5) leave `flag_c` unchanged.
- R9: The results appear on the clock edge after the one on which `req_valid` is sampled high. `res_done` is high for exactly that one cycle, and both write strobes are high only in a `res_done` cycle.
- R10: Opcodes 6 and 7 still pulse `res_done`. They assert neither write strobe and change neither flag nor `res_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation code (0 test, 1 set, 2 clear, 3 invert, 4 forward scan, 5 reverse scan) |
| req_wide | input | 1 | Operand size: 1 = 32-bit, 0 = 16-bit |
| req_data | input | 32 | Operand |
| req_pos | input | 5 | Bit position, reduced modulo the operand width |
| res_data | output | 32 | Operand after modification |
| res_data_we | output | 1 | Write strobe for `res_data` |
| res_index | output | 5 | Bit position found by a scan |
| res_index_we | output | 1 | Write strobe for `res_index` |
| flag_c | output | 1 | Carry flag, the bit chosen by the last test operation |
| flag_z | output | 1 | Zero flag, set when the last scan found no 1 bit |
| res_done | output | 1 | One-cycle pulse marking a result |

## Verification
The modify operations are driven at both ends and in the middle of the operand, with the selected bit starting both as 0 and as 1. This separates a set from an invert and shows whether the carry holds the original bit or the modified one. The scans use operands with a single set bit, with many set bits and with no set bit at all. Only many set bits tells a forward search from a reverse one, and the zero operand checks that the earlier index is kept. The 16-bit cases use positions of 16 and above and operands with set bits only in the upper half, which shows whether the modulo reduction and the scan masking are in place. Flag persistence is checked by alternating test and scan operations and watching that the flag an operation does not own stays where it was.

// File: rtl/bitu_pkg.sv
// Shared operation codes for the bit test, modify and scan unit.
// Assumes a 3-bit opcode field. Codes 6 and 7 are left undefined and produce no effect.
package bitu_pkg;

    typedef enum logic [2:0] {
        OP_TEST    = 3'd0,
        OP_SET     = 3'd1,
        OP_CLEAR   = 3'd2,
        OP_INVERT  = 3'd3,
        OP_SCAN_LO = 3'd4,
        OP_SCAN_HI = 3'd5
    } op_e;

    // True for the four operations that sample a bit into carry
    function automatic logic is_test_op(input logic [2:0] code);
        return code <= 3'd3;
    endfunction

    // True for the two search operations
    function automatic logic is_scan_op(input logic [2:0] code);
        return (code == 3'd4) || (code == 3'd5);
    endfunction

endpackage

// File: rtl/bitu_modify.sv
// Single-bit test and modify datapath, purely combinational.
// Reduces the bit position modulo the operand width and picks out the selected bit.
// Then forms the set, clear or invert result.
// Assumes NARROW_W is a power of two no larger than DATA_W.
module bitu_modify #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    localparam int POS_W   = $clog2(DATA_W),
    localparam int NPOS_W  = $clog2(NARROW_W)
) (
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic [DATA_W-1:0] data,
    input  logic [POS_W-1:0]  pos,
    output logic [POS_W-1:0]  pos_eff,
    output logic              sel_bit,
    output logic [DATA_W-1:0] result,
    output logic              write
);

    logic [DATA_W-1:0] bit_mask;

    // Reduce the position to the active operand width
    always_comb begin
        if (wide) begin
            pos_eff = pos;
        end else begin
            pos_eff = POS_W'(pos[NPOS_W-1:0]);
        end
    end

    // One-hot mask for the chosen bit and the original bit value
    always_comb begin
        bit_mask = '0;
        bit_mask[pos_eff] = 1'b1;
        sel_bit  = data[pos_eff];
    end

    // Apply the requested change; other codes pass the operand through
    always_comb begin
        result = data;
        write  = 1'b0;
        unique case (op)
            bitu_pkg::OP_SET: begin
                result = data | bit_mask;
                write  = 1'b1;
            end
            bitu_pkg::OP_CLEAR: begin
                result = data & ~bit_mask;
                write  = 1'b1;
            end
            bitu_pkg::OP_INVERT: begin
                result = data ^ bit_mask;
                write  = 1'b1;
            end
            default: begin
                result = data;
                write  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitu_scan.sv
// Bit search datapath, purely combinational.
// Masks the operand to the active width, then finds the lowest and the highest set bit.
// Also flags an operand with no set bit.
// Assumes NARROW_W is no larger than DATA_W.
module bitu_scan #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] data,
    output logic [POS_W-1:0]  lo_idx,
    output logic [POS_W-1:0]  hi_idx,
    output logic              none
);

    logic [DATA_W-1:0] masked;

    // Keep the low part always; gate the upper part by the size select
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_mask
            if (g < NARROW_W) begin : g_low
                assign masked[g] = data[g];
            end else begin : g_high
                assign masked[g] = data[g] & wide;
            end
        end
    endgenerate

    // Lowest set bit: walk downwards so the last hit is the lowest
    always_comb begin
        lo_idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (masked[i]) lo_idx = POS_W'(i);
        end
    end

    // Highest set bit: walk upwards so the last hit is the highest
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (masked[i]) hi_idx = POS_W'(i);
        end
    end

    // Empty operand detection
    always_comb begin
        none = (masked == '0);
    end

endmodule

// File: rtl/bit_ops_unit.sv
// Bit test, modify and scan unit.
// Takes one request per strobe and registers every result one clock later with a done pulse.
// Carry is owned by the test operations and zero by the scans; each flag holds otherwise.
// Assumes req_valid is a single-cycle strobe; reset is synchronous, active low.
module bit_ops_unit #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_wide,
    input  logic [DATA_W-1:0] req_data,
    input  logic [POS_W-1:0]  req_pos,
    output logic [DATA_W-1:0] res_data,
    output logic              res_data_we,
    output logic [POS_W-1:0]  res_index,
    output logic              res_index_we,
    output logic              flag_c,
    output logic              flag_z,
    output logic              res_done
);

    logic [POS_W-1:0]  pos_eff;
    logic              sel_bit;
    logic [DATA_W-1:0] mod_result;
    logic              mod_write;
    logic [POS_W-1:0]  lo_idx;
    logic [POS_W-1:0]  hi_idx;
    logic              scan_none;
    logic              do_test;
    logic              do_scan;
    logic [POS_W-1:0]  found_idx;

    bitu_modify #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) i_modify (
        .op      (req_op),
        .wide    (req_wide),
        .data    (req_data),
        .pos     (req_pos),
        .pos_eff (pos_eff),
        .sel_bit (sel_bit),
        .result  (mod_result),
        .write   (mod_write)
    );

    bitu_scan #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) i_scan (
        .wide   (req_wide),
        .data   (req_data),
        .lo_idx (lo_idx),
        .hi_idx (hi_idx),
        .none   (scan_none)
    );

    // Classify the request and choose the search direction
    always_comb begin
        do_test   = req_valid && bitu_pkg::is_test_op(req_op);
        do_scan   = req_valid && bitu_pkg::is_scan_op(req_op);
        found_idx = (req_op == bitu_pkg::OP_SCAN_HI) ? hi_idx : lo_idx;
    end

    // Result registers, write strobes and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data     <= '0;
            res_data_we  <= 1'b0;
            res_index    <= '0;
            res_index_we <= 1'b0;
            res_done     <= 1'b0;
        end else begin
            res_done     <= req_valid;
            res_data_we  <= req_valid && mod_write;
            res_index_we <= do_scan && !scan_none;
            if (req_valid) begin
                res_data <= mod_result;
            end
            if (do_scan && !scan_none) begin
                res_index <= found_idx;
            end
        end
    end

    // Carry flag register, written only by test operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_c <= 1'b0;
        end else if (do_test) begin
            flag_c <= sel_bit;
        end
    end

    // Zero flag register, written only by scans
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_z <= 1'b0;
        end else if (do_scan) begin
            flag_z <= scan_none;
        end
    end

    // Write strobes only appear together with the done pulse (R9)
    p_we_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_data_we || res_index_we) |-> res_done);

    // Done is a single-cycle pulse for single-cycle strobes (R9)
    p_done_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_done == $past(req_valid)));

    // Carry holds the original selected bit after a test operation (R2)
    p_carry_original_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(do_test)) |-> (flag_c == $past(req_data[pos_eff])));

    // Plain test never writes the operand (R2)
    p_plain_test_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_op) == 3'd0) |-> !res_data_we);

    // A scan that finds nothing leaves the index alone (R7)
    p_empty_scan_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(do_scan) && flag_z) |-> (!res_index_we && $stable(res_index)));

    // Test operations leave the zero flag where it was (R8)
    p_test_keeps_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(do_test)) |-> $stable(flag_z));

    // Scans leave the carry flag where it was (R8)
    p_scan_keeps_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(do_scan)) |-> $stable(flag_c));

endmodule

// File: tb/test_bit_ops_unit.sv
// Directed bench for bit_ops_unit: one task per scenario, expected values from the requirements.
module test_bit_ops_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic        req_wide = 1'b1;
    logic [31:0] req_data = '0;
    logic [4:0]  req_pos = '0;
    logic [31:0] res_data;
    logic        res_data_we;
    logic [4:0]  res_index;
    logic        res_index_we;
    logic        flag_c;
    logic        flag_z;
    logic        res_done;

    int checks = 0;
    int errors = 0;

    // Expected persistent state
    logic       exp_c = 1'b0;
    logic       exp_z = 1'b0;
    logic [4:0] exp_idx = '0;

    bit_ops_unit i_bit_ops_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_wide     (req_wide),
        .req_data     (req_data),
        .req_pos      (req_pos),
        .res_data     (res_data),
        .res_data_we  (res_data_we),
        .res_index    (res_index),
        .res_index_we (res_index_we),
        .flag_c       (flag_c),
        .flag_z       (flag_z),
        .res_done     (res_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one request, compute expectations from the requirements, check every output
    task automatic run(input string req, input logic [2:0] op, input logic wide,
                       input logic [31:0] d, input logic [4:0] pos);
        logic [4:0]  p;
        logic [31:0] m;
        logic [31:0] scan_d;
        logic [31:0] exp_data;
        logic        exp_dwe;
        logic        exp_iwe;
        p = wide ? pos : {1'b0, pos[3:0]};
        m = 32'd1 << p;
        scan_d = wide ? d : (d & 32'h0000_FFFF);
        exp_data = d;
        exp_dwe = 1'b0;
        exp_iwe = 1'b0;
        if (op <= 3'd3) exp_c = d[p];
        case (op)
            3'd1: begin exp_data = d | m;  exp_dwe = 1'b1; end
            3'd2: begin exp_data = d & ~m; exp_dwe = 1'b1; end
            3'd3: begin exp_data = d ^ m;  exp_dwe = 1'b1; end
            3'd4, 3'd5: begin
                exp_z = (scan_d == 0);
                if (scan_d != 0) begin
                    exp_iwe = 1'b1;
                    for (int i = 0; i < 32; i++) begin
                        if (scan_d[i] && (op == 3'd5)) exp_idx = 5'(i);
                    end
                    for (int i = 31; i >= 0; i--) begin
                        if (scan_d[i] && (op == 3'd4)) exp_idx = 5'(i);
                    end
                end
            end
            default: ;
        endcase
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_wide  = wide;
        req_data  = d;
        req_pos   = pos;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "done", 32'(res_done), 32'd1);
        chk(req, "data", res_data, exp_data);
        chk(req, "data_we", 32'(res_data_we), 32'(exp_dwe));
        chk(req, "index", 32'(res_index), 32'(exp_idx));
        chk(req, "index_we", 32'(res_index_we), 32'(exp_iwe));
        chk(req, "flag_c", 32'(flag_c), 32'(exp_c));
        chk(req, "flag_z", 32'(flag_z), 32'(exp_z));
        @(negedge clk);
        chk("R9", "done pulse ends", 32'(res_done), 32'd0);
        chk("R9", "strobes end", 32'(res_data_we | res_index_we), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "data", res_data, 32'd0);
        chk("R1", "index", 32'(res_index), 32'd0);
        chk("R1", "flags", 32'({flag_c, flag_z}), 32'd0);
        chk("R1", "strobes", 32'({res_data_we, res_index_we, res_done}), 32'd0);
    endtask

    task automatic t_plain_test();
        run("R2", 3'd0, 1'b1, 32'h8000_0001, 5'd31);
        run("R2", 3'd0, 1'b1, 32'h8000_0001, 5'd30);
        run("R2", 3'd0, 1'b1, 32'h0000_0001, 5'd0);
    endtask

    task automatic t_modify();
        run("R3", 3'd1, 1'b1, 32'h0000_0000, 5'd31);
        run("R3", 3'd1, 1'b1, 32'hFFFF_FFFF, 5'd7);
        run("R3", 3'd2, 1'b1, 32'hFFFF_FFFF, 5'd0);
        run("R3", 3'd2, 1'b1, 32'h0000_0000, 5'd15);
        run("R3", 3'd3, 1'b1, 32'h1234_5678, 5'd3);
        run("R3", 3'd3, 1'b1, 32'h1234_5678, 5'd4);
    endtask

    task automatic t_narrow_pos();
        run("R4", 3'd1, 1'b0, 32'hA5A5_0000, 5'd20);
        run("R4", 3'd3, 1'b0, 32'hFFFF_FFFF, 5'd31);
        run("R4", 3'd0, 1'b0, 32'h0001_0000, 5'd16);
        run("R4", 3'd2, 1'b1, 32'hFFFF_FFFF, 5'd20);
    endtask

    task automatic t_scans();
        run("R5", 3'd4, 1'b1, 32'h0000_0100, 5'd0);
        run("R5", 3'd4, 1'b1, 32'h8001_0600, 5'd0);
        run("R6", 3'd5, 1'b1, 32'h8001_0600, 5'd0);
        run("R6", 3'd5, 1'b1, 32'h0000_0001, 5'd0);
        run("R5", 3'd4, 1'b0, 32'hF000_8000, 5'd0);
        run("R6", 3'd5, 1'b0, 32'hF000_0012, 5'd0);
    endtask

    task automatic t_empty_scan();
        run("R7", 3'd5, 1'b1, 32'h0000_4000, 5'd0);
        run("R7", 3'd4, 1'b1, 32'h0000_0000, 5'd0);
        run("R7", 3'd5, 1'b0, 32'hFFFF_0000, 5'd0);
        run("R7", 3'd4, 1'b1, 32'h0000_0002, 5'd0);
    endtask

    task automatic t_flag_ownership();
        run("R8", 3'd4, 1'b1, 32'h0000_0000, 5'd0);
        run("R8", 3'd1, 1'b1, 32'h0000_0008, 5'd3);
        run("R8", 3'd5, 1'b1, 32'h0000_0000, 5'd0);
        run("R8", 3'd0, 1'b1, 32'h0000_0000, 5'd9);
        run("R8", 3'd4, 1'b1, 32'h0000_0040, 5'd0);
    endtask

    task automatic t_undefined();
        run("R2", 3'd0, 1'b1, 32'h0000_0001, 5'd0);
        run("R10", 3'd6, 1'b1, 32'h0000_0000, 5'd0);
        run("R10", 3'd7, 1'b0, 32'hFFFF_FFFF, 5'd2);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 3'd0;
        req_wide = 1'b1;
        req_data = 32'h0;
        req_pos = 5'd0;
        @(posedge clk);
        chk("R9", "no early done", 32'(res_done), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "done next cycle", 32'(res_done), 32'd1);
        exp_c = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_test();
        t_modify();
        t_narrow_pos();
        t_scans();
        t_empty_scan();
        t_flag_ownership();
        t_undefined();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule